// File: doc/BRIEF.md
# Warp Divergence Mask Stack

This block tracks which lanes of a 32-lane warp are enabled and where the warp goes next when it meets two-way branches. All lanes share one instruction stream. When the enabled lanes disagree on a branch, the two sides cannot run together. The block first runs the lanes that took the branch at the target address. It then runs the remaining lanes at the fall-through address. After that it restores the mask the warp had before the branch and resumes at the join address. During an even split each side keeps only half of the lanes busy, so the branch region costs about twice its undivided time.

The fetch stage reports each branch with a per-lane predicate and three addresses: target, fall-through and join. It raises a separate strobe when the warp reaches the join point of the innermost open branch. A uniform branch only moves the program counter. A divergent branch stores two entries on an internal stack of parameterised depth. The first entry holds the join address with the pre-branch mask. The second holds the fall-through address with the lanes that did not take the branch. Each join strobe restores the newest stored entry.

A controller with three states, CONVERGED, DIVERGED and FAULT, sequences the work. The transitions are:
- SPLIT_OPEN: CONVERGED to DIVERGED on a divergent branch.
- LAST_JOIN: DIVERGED to CONVERGED when the last stored entry is restored.
- STACK_FULL: CONVERGED or DIVERGED to FAULT on a divergent branch with too little stack room.
- Reset is the only way out of FAULT.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the next PC equals parameter RESET_PC, the stack level is 0, the overflow flag is 0 and the mode is 0.
- R2: A branch on which every enabled lane has predicate 1 sets the next PC to the target. The mask and the stack level are unchanged.
- R3: A branch on which no enabled lane has predicate 1 sets the next PC to the fall-through address. The mask and the stack level are unchanged.
- R4: A divergent branch raises the stack level by 2. It stores the join entry (pre-branch mask, join PC) and then the fall-through entry (not-taken enabled lanes, fall-through PC). The active mask becomes the enabled lanes with predicate 1, and the next PC becomes the target.
- R5: Predicate bits of lanes disabled before a branch are ignored. Those lanes stay disabled on both sides of the branch.
- R6: A join strobe with a non-empty stack copies the newest entry's mask and PC to the outputs and lowers the level by 1.
- R7: A join strobe with an empty stack changes nothing.
- R8: When a branch and a join strobe arrive in the same cycle, the branch is handled and the strobe is dropped.
- R9: A divergent branch with fewer than two free entries sets the sticky overflow flag and leaves the mask, PC and level unchanged. Every later event is ignored until reset.
- R10: The mode output reads 0 in CONVERGED (level 0), 1 in DIVERGED and 2 in FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch event this cycle |
| br_pred | input | LANES | Per-lane outcome, 1 = taken |
| br_target | input | PC_W | Address of the taken side |
| br_fallthru | input | PC_W | Address of the not-taken side |
| br_join | input | PC_W | Address where the two sides meet |
| join_hit | input | 1 | Warp has reached the innermost join point |
| active_mask | output | LANES | Lanes currently enabled |
| next_pc | output | PC_W | Address the warp executes next |
| stack_level | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow_err | output | 1 | Sticky stack-overflow flag |
| mode | output | 2 | Controller state encoding |

## Verification
A corrupted stack entry shows up only when it is restored. It appears one cycle after the join strobe that pops it, as a wrong mask or a wrong PC. For this reason the stimulus nests two branches and then unwinds all four entries. A level counter that drifts shows up at once on stack_level and mode. It also surfaces later, when a branch reports overflow too early or too late. Lanes leaking through from disabled positions show up on active_mask in the cycle right after the branch.

// File: rtl/simt_pkg.sv
package simt_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_DIV   = 2'd1,
        ST_FAULT = 2'd2
    } warp_state_e;

    typedef enum logic [1:0] {
        BK_ALL_NOT = 2'd0,
        BK_ALL_TKN = 2'd1,
        BK_SPLIT   = 2'd2
    } branch_kind_e;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_JUMP_T = 3'd1,
        ACT_JUMP_F = 3'd2,
        ACT_SPLIT  = 3'd3,
        ACT_POP    = 3'd4,
        ACT_OVF    = 3'd5
    } warp_action_e;

endpackage

// File: rtl/lane_split.sv
module lane_split
    import simt_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] taken_lanes,
    output logic [LANES-1:0] ntaken_lanes,
    output branch_kind_e     kind
);

    always_comb begin
        taken_lanes  = cur_mask & pred;
        ntaken_lanes = cur_mask & ~pred;
        if (taken_lanes == '0) begin
            kind = BK_ALL_NOT;
        end else if (ntaken_lanes == '0) begin
            kind = BK_ALL_TKN;
        end else begin
            kind = BK_SPLIT;
        end
    end

endmodule

// File: rtl/div_stack.sv
module div_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push2,
    input  logic             pop,
    input  logic [LANES-1:0] join_mask,
    input  logic [PC_W-1:0]  join_pc,
    input  logic [LANES-1:0] alt_mask,
    input  logic [PC_W-1:0]  alt_pc,
    output logic [LANES-1:0] top_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [LVL_W-1:0] level,
    output logic             room2,
    output logic             empty,
    output logic             last_one
);

    logic [LANES-1:0] mask_q [DEPTH];
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [LVL_W-1:0] level_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= '0;
                pc_q[i]   <= '0;
            end else if (push2) begin
                if (level_q == LVL_W'(i)) begin
                    mask_q[i] <= join_mask;
                    pc_q[i]   <= join_pc;
                end else if ((level_q + LVL_W'(1)) == LVL_W'(i)) begin
                    mask_q[i] <= alt_mask;
                    pc_q[i]   <= alt_pc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (push2) begin
            level_q <= level_q + LVL_W'(2);
        end else if (pop && level_q != '0) begin
            level_q <= level_q - LVL_W'(1);
        end
    end

    always_comb begin
        top_mask = '0;
        top_pc   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LVL_W'(i + 1)) begin
                top_mask = mask_q[i];
                top_pc   = pc_q[i];
            end
        end
    end

    assign level    = level_q;
    assign empty    = (level_q == '0);
    assign last_one = (level_q == LVL_W'(1));
    assign room2    = (int'(level_q) + 2 <= DEPTH);

    // R9
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push2 |-> (int'(level_q) + 2 <= DEPTH));

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_q) <= DEPTH);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push2 && level_q == '0) |=> level_q == '0);

endmodule

// File: rtl/warp_ctrl.sv
module warp_ctrl
    import simt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         br_valid,
    input  logic         join_hit,
    input  branch_kind_e kind,
    input  logic         room2,
    input  logic         empty,
    input  logic         last_one,
    output warp_action_e action,
    output logic [1:0]   mode
);

    warp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONV;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        action  = ACT_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_CONV, ST_DIV: begin
                if (br_valid) begin
                    unique case (kind)
                        BK_ALL_TKN: action = ACT_JUMP_T;
                        BK_ALL_NOT: action = ACT_JUMP_F;
                        default:    action = room2 ? ACT_SPLIT : ACT_OVF;
                    endcase
                end else if (join_hit && !empty) begin
                    action = ACT_POP;
                end
                if (action == ACT_OVF) begin
                    state_d = ST_FAULT;
                end else if (action == ACT_SPLIT) begin
                    state_d = ST_DIV;
                end else if (action == ACT_POP && last_one) begin
                    state_d = ST_CONV;
                end
            end
            ST_FAULT: begin
                action  = ACT_NONE;
                state_d = ST_FAULT;
            end
            default: begin
                action  = ACT_NONE;
                state_d = ST_FAULT;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_CONV:  mode = 2'd0;
            ST_DIV:   mode = 2'd1;
            default:  mode = 2'd2;
        endcase
    end

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FAULT |=> state_q == ST_FAULT);

    // R10
    conv_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CONV |-> empty);

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int PC_W     = 32,
    parameter int DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_join,
    input  logic             join_hit,
    output logic [LANES-1:0] active_mask,
    output logic [PC_W-1:0]  next_pc,
    output logic [LVL_W-1:0] stack_level,
    output logic             overflow_err,
    output logic [1:0]       mode
);

    logic [LANES-1:0] mask_q;
    logic [PC_W-1:0]  pc_q;
    logic [LANES-1:0] taken_lanes, ntaken_lanes, top_mask;
    logic [PC_W-1:0]  top_pc;
    logic             room2, empty, last_one;
    branch_kind_e     kind;
    warp_action_e     action;

    lane_split #(.LANES(LANES)) u_split (
        .cur_mask     (mask_q),
        .pred         (br_pred),
        .taken_lanes  (taken_lanes),
        .ntaken_lanes (ntaken_lanes),
        .kind         (kind)
    );

    warp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .join_hit (join_hit),
        .kind     (kind),
        .room2    (room2),
        .empty    (empty),
        .last_one (last_one),
        .action   (action),
        .mode     (mode)
    );

    div_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push2     (action == ACT_SPLIT),
        .pop       (action == ACT_POP),
        .join_mask (mask_q),
        .join_pc   (br_join),
        .alt_mask  (ntaken_lanes),
        .alt_pc    (br_fallthru),
        .top_mask  (top_mask),
        .top_pc    (top_pc),
        .level     (stack_level),
        .room2     (room2),
        .empty     (empty),
        .last_one  (last_one)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            pc_q   <= RESET_PC;
        end else begin
            unique case (action)
                ACT_JUMP_T: pc_q <= br_target;
                ACT_JUMP_F: pc_q <= br_fallthru;
                ACT_SPLIT: begin
                    mask_q <= taken_lanes;
                    pc_q   <= br_target;
                end
                ACT_POP: begin
                    mask_q <= top_mask;
                    pc_q   <= top_pc;
                end
                default: ;
            endcase
        end
    end

    assign active_mask  = mask_q;
    assign next_pc      = pc_q;
    assign overflow_err = (mode == 2'd2);

    // R5
    no_new_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !overflow_err) |=> (active_mask & ~$past(active_mask)) == '0);

    // R6
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (join_hit && !br_valid && !overflow_err && stack_level != '0)
        |=> stack_level == $past(stack_level) - LVL_W'(1));

    // R7
    idle_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (join_hit && !br_valid && stack_level == '0)
        |=> $stable(active_mask) && $stable(next_pc));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err && $stable(active_mask) && $stable(next_pc)
                         && $stable(stack_level));

endmodule

// File: tb/simt_mask_stack_bench.sv
module simt_mask_stack_bench;

    localparam int LANES = 32;
    localparam int PC_W  = 32;
    localparam int DEPTH = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic        v;
        logic        h;
        logic [31:0] pred;
        logic [15:0] tgt;
        logic [15:0] ft;
        logic [15:0] jn;
        logic [31:0] e_mask;
        logic [15:0] e_pc;
        logic [3:0]  e_lvl;
        logic [1:0]  e_mode;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t TAB [NSTEP] = '{
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 16'h100, 16'h010, 16'h200, 32'hFFFF_FFFF, 16'h100, 4'd0, 2'd0, 4'd2},  // R2
        '{1'b1, 1'b0, 32'h0000_0000, 16'h300, 16'h104, 16'h200, 32'hFFFF_FFFF, 16'h104, 4'd0, 2'd0, 4'd3},  // R3
        '{1'b1, 1'b0, 32'h0000_FFFF, 16'h400, 16'h108, 16'h500, 32'h0000_FFFF, 16'h400, 4'd2, 2'd1, 4'd4},  // R4
        '{1'b1, 1'b0, 32'hFF00_00FF, 16'h600, 16'h410, 16'h700, 32'h0000_00FF, 16'h600, 4'd4, 2'd1, 4'd5},  // R5
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'h0000_FF00, 16'h410, 4'd3, 2'd1, 4'd6},  // R6
        '{1'b1, 1'b0, 32'hFFFF_FF00, 16'h480, 16'h414, 16'h700, 32'h0000_FF00, 16'h480, 4'd3, 2'd1, 4'd5},  // R5
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'h0000_FFFF, 16'h700, 4'd2, 2'd1, 4'd6},  // R6
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'hFFFF_0000, 16'h108, 4'd1, 2'd1, 4'd6},  // R6
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'hFFFF_FFFF, 16'h500, 4'd0, 2'd0, 4'd10}, // R10
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'hFFFF_FFFF, 16'h500, 4'd0, 2'd0, 4'd7},  // R7
        '{1'b1, 1'b1, 32'h0F0F_0F0F, 16'h800, 16'h50C, 16'h900, 32'h0F0F_0F0F, 16'h800, 4'd2, 2'd1, 4'd8},  // R8
        '{1'b0, 1'b0, 32'h0,         16'h0,   16'h0,   16'h0,   32'h0F0F_0F0F, 16'h800, 4'd2, 2'd1, 4'd8},  // R8
        '{1'b1, 1'b0, 32'h0000_0F0F, 16'hA00, 16'h804, 16'hB00, 32'h0000_0F0F, 16'hA00, 4'd4, 2'd1, 4'd4},  // R4
        '{1'b1, 1'b0, 32'h0000_000F, 16'hC00, 16'hA04, 16'hD00, 32'h0000_0F0F, 16'hA00, 4'd4, 2'd2, 4'd9},  // R9
        '{1'b0, 1'b1, 32'h0,         16'h0,   16'h0,   16'h0,   32'h0000_0F0F, 16'hA00, 4'd4, 2'd2, 4'd9}   // R9
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_join = '0;
    logic             join_hit = 1'b0;
    logic [LANES-1:0] active_mask;
    logic [PC_W-1:0]  next_pc;
    logic [LVL_W-1:0] stack_level;
    logic             overflow_err;
    logic [1:0]       mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC('0))
    u_simt_mask_stack (
        .clk, .rst_n, .br_valid, .br_pred, .br_target, .br_fallthru, .br_join,
        .join_hit, .active_mask, .next_pc, .stack_level, .overflow_err, .mode
    );

    task automatic check_state(input int req, input logic [31:0] em, input logic [31:0] ep,
                               input int el, input logic [1:0] emd, input logic eo);
        checks++;
        if (active_mask !== em || next_pc !== ep || int'(stack_level) != el ||
            mode !== emd || overflow_err !== eo) begin
            errors++;
            $display("FAIL R%0d: mask %h pc %h lvl %0d mode %0d ovf %0b, expected mask %h pc %h lvl %0d mode %0d ovf %0b",
                     req, active_mask, next_pc, stack_level, mode, overflow_err,
                     em, ep, el, emd, eo);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_state(1, 32'hFFFF_FFFF, 32'h0, 0, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state(1, 32'hFFFF_FFFF, 32'h0, 0, 2'd0, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            br_valid    = TAB[i].v;
            join_hit    = TAB[i].h;
            br_pred     = TAB[i].pred;
            br_target   = 32'(TAB[i].tgt);
            br_fallthru = 32'(TAB[i].ft);
            br_join     = 32'(TAB[i].jn);
            @(negedge clk);
            check_state(int'(TAB[i].req), TAB[i].e_mask, 32'(TAB[i].e_pc),
                        int'(TAB[i].e_lvl), TAB[i].e_mode, TAB[i].e_mode == 2'd2);
            if (i == 2) begin
                // R4: even split leaves half of the lanes on the taken side
                checks++;
                if ($countones(active_mask) != 16) begin
                    errors++;
                    $display("FAIL R4: active lanes %0d, expected 16", $countones(active_mask));
                end
            end
        end

        // R9: uniform branch in fault is also ignored
        br_valid = 1'b1; join_hit = 1'b0; br_pred = '1;
        br_target = 32'hE00; br_fallthru = 32'hE04;
        @(negedge clk);
        check_state(9, 32'h0000_0F0F, 32'hA00, 4, 2'd2, 1'b1);

        // R1: reset clears the fault
        br_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state(1, 32'hFFFF_FFFF, 32'h0, 0, 2'd0, 1'b0);

        // R3 after reset: all lanes not taken
        br_valid = 1'b1; br_pred = '0; br_fallthru = 32'h44;
        @(negedge clk);
        check_state(3, 32'hFFFF_FFFF, 32'h44, 0, 2'd0, 1'b0);
        br_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule